// File: doc/BRIEF.md
# Multi-Source Pending Write Tracker

This block keeps a pending-result counter for every destination register that an outstanding load will write. A load access can carry lanes from several warps, or from several co-issued subsets (splits) of one warp, after those lanes were merged into one memory request. Such an access therefore names a list of sources. Each source carries its warp, its split code and up to four destination register slots. At issue, every source in the list adds one to the counter of each of its valid destination registers. At writeback, the same list is walked and each of those counters is decremented. A register is handed back to the scoreboard in the cycle after its counter reaches zero, which happens only when the last access that touches it has returned.

There are two counter banks. The primary bank is indexed by warp and register. The secondary bank is indexed by warp, split and register, so co-issued subsets of one warp can target the same register number without sharing a count. When an access carries no explicit list, it is counted against its single stamp. Shared-memory loads bypass the counters completely. Overflow and underflow are reported as one-cycle error pulses.

Top module: `ptrk_top`

## Requirements
- R1: After reset every counter is zero, and all release bitmaps, `instComplete`, `underflowErr` and `overflowErr` are low.
- R2: A non-shared issue adds one to the counter of every valid destination slot (`used`=1) of every valid source in the effective list. A shared issue changes no counter.
- R3: A split code of all ones (3) selects the primary bank, which appears as `relPrimary` bit warp*16+reg. Split 0 or 1 selects the secondary bank, which appears as `relSecondary` bit (warp*2+split)*16+reg. A source with split code 2 is ignored on both ports.
- R4: When no entry of the source list is valid, the stamp is used as a one-entry list. If the stamp's `valid` bit is 0, the entry uses the primary-warp input, the primary bank and the stamp's destination slots.
- R5: A non-shared writeback subtracts one from each counter it names. A counter that moves from 1 to 0 sets its release bit for exactly one cycle, in the cycle after the writeback. A counter that is still above zero releases nothing.
- R6: One writeback with several sources retires counts for all of them in the same cycle, across both banks.
- R7: `instComplete` pulses in the same cycle as the release bits, if and only if at least one register was released.
- R8: A writeback that names a counter which is already zero raises `underflowErr` for one cycle. The counter stays at zero and no release occurs.
- R9: An issue that names a counter already at 15 raises `overflowErr` for one cycle, and the counter stays at 15.
- R10: A shared writeback sets the release bits of all its registers directly, in the next cycle, and leaves the counters unchanged.
- R11: When an issue and a non-shared writeback name the same counter in one cycle, the counter is unchanged, and neither a release nor an error occurs for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue of one access this cycle |
| issueShared | input | 1 | Issued access is a shared-memory load |
| issueSrcs | input | 104 | Four source entries of 26 bits: valid, warp[3], split[2], four slots of {used, reg[4]} |
| issueStamp | input | 26 | Single-stamp source used when the list is empty |
| issuePrimWarp | input | 3 | Primary warp used when the stamp is unset |
| wbValid | input | 1 | Writeback of one access this cycle |
| wbShared | input | 1 | Returning access is a shared-memory load |
| wbSrcs | input | 104 | Source list of the returning access |
| wbStamp | input | 26 | Single stamp of the returning access |
| wbPrimWarp | input | 3 | Primary warp of the returning access |
| relPrimary | output | 128 | One-cycle release bitmap for the primary bank |
| relSecondary | output | 256 | One-cycle release bitmap for the secondary bank |
| instComplete | output | 1 | At least one register released this cycle |
| underflowErr | output | 1 | A writeback named a zero counter |
| overflowErr | output | 1 | An issue named a saturated counter |

## Verification
A counter that holds a wrong value stays invisible until its register's last access returns. At that point the release bit fires one writeback too early, fires one too late, or never fires, and an extra decrement shows up as an `underflowErr` pulse. A wrong bank choice shows up as a release bit at another position or in the other bitmap, in the cycle after the writeback. The bench models every counter and compares both bitmaps and all three pulses in every cycle. Because of this, a corrupted count is caught at the first writeback that touches that register.

// File: rtl/ptrk_pkg.sv
`timescale 1ns/1ps
package ptrk_pkg;
  parameter int NumWarps  = 8;
  parameter int NumSplits = 2;
  parameter int NumSlots  = 4;
  parameter int NumRegs   = 16;
  parameter int CntWidth  = 4;
  parameter int MaxSrc    = 4;

  localparam int WarpBits  = $clog2(NumWarps);
  localparam int RegBits   = $clog2(NumRegs);
  localparam int SplitBits = $clog2(NumSplits + 1);
  localparam logic [SplitBits-1:0] PrimarySplit = '1;
  localparam int PrimCtrs  = NumWarps * NumRegs;
  localparam int SecCtrs   = NumWarps * NumSplits * NumRegs;
  localparam int NumCtrs   = PrimCtrs + SecCtrs;

  typedef struct packed {
    logic               used;
    logic [RegBits-1:0] regIdx;
  } dst_slot_t;

  typedef struct packed {
    logic                          valid;
    logic [WarpBits-1:0]           warp;
    logic [SplitBits-1:0]          split;
    dst_slot_t [NumSlots-1:0]      dst;
  } src_entry_t;

  typedef src_entry_t [MaxSrc-1:0] src_list_t;

  typedef struct packed {
    logic [NumCtrs-1:0] inc;
    logic [NumCtrs-1:0] dec;
    logic [NumCtrs-1:0] direct;
  } strobe_t;

  function automatic logic splitOk(logic [SplitBits-1:0] split);
    return (split == PrimarySplit) || (int'(split) < NumSplits);
  endfunction

  function automatic int ctrIndex(logic [WarpBits-1:0] warp,
                                  logic [SplitBits-1:0] split,
                                  logic [RegBits-1:0] regIdx);
    if (split == PrimarySplit) return int'(warp) * NumRegs + int'(regIdx);
    return PrimCtrs + (int'(warp) * NumSplits + int'(split)) * NumRegs + int'(regIdx);
  endfunction
endpackage

// File: rtl/ptrk_ctrl.sv
`timescale 1ns/1ps
module ptrk_ctrl import ptrk_pkg::*; (
  input  logic                issueValid,
  input  logic                issueShared,
  input  src_list_t           issueSrcs,
  input  src_entry_t          issueStamp,
  input  logic [WarpBits-1:0] issuePrimWarp,
  input  logic                wbValid,
  input  logic                wbShared,
  input  src_list_t           wbSrcs,
  input  src_entry_t          wbStamp,
  input  logic [WarpBits-1:0] wbPrimWarp,
  output strobe_t             strobe
);
  // Empty list falls back to the single stamp; an unset stamp means primary.
  function automatic src_list_t effList(src_list_t l, src_entry_t st,
                                        logic [WarpBits-1:0] pw);
    src_list_t res;
    logic anyValid;
    anyValid = 1'b0;
    for (int s = 0; s < MaxSrc; s++) anyValid |= l[s].valid;
    if (anyValid) return l;
    res = '0;
    res[0] = st;
    res[0].valid = 1'b1;
    if (!st.valid) begin
      res[0].warp  = pw;
      res[0].split = PrimarySplit;
    end
    return res;
  endfunction

  function automatic logic [NumCtrs-1:0] markVec(src_list_t l);
    logic [NumCtrs-1:0] v;
    v = '0;
    for (int s = 0; s < MaxSrc; s++)
      for (int d = 0; d < NumSlots; d++)
        if (l[s].valid && l[s].dst[d].used && splitOk(l[s].split))
          v[ctrIndex(l[s].warp, l[s].split, l[s].dst[d].regIdx)] = 1'b1;
    return v;
  endfunction

  logic [NumCtrs-1:0] issueMarks, wbMarks;

  always_comb begin
    issueMarks    = markVec(effList(issueSrcs, issueStamp, issuePrimWarp));
    wbMarks       = markVec(effList(wbSrcs, wbStamp, wbPrimWarp));
    strobe.inc    = (issueValid && !issueShared) ? issueMarks : '0;
    strobe.dec    = (wbValid && !wbShared) ? wbMarks : '0;
    strobe.direct = (wbValid && wbShared) ? wbMarks : '0;
  end
endmodule

// File: rtl/ptrk_datapath.sv
`timescale 1ns/1ps
module ptrk_datapath import ptrk_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  output logic [NumCtrs-1:0] relVec,
  output logic               instComplete,
  output logic               underflowErr,
  output logic               overflowErr
);
  localparam logic [CntWidth-1:0] CntMax = '1;
  localparam logic [CntWidth-1:0] CntOne = CntWidth'(1);

  logic [CntWidth-1:0] cnt     [NumCtrs];
  logic [CntWidth-1:0] cntNext [NumCtrs];
  logic [NumCtrs-1:0]  relNext, underV, overV;

  always_comb begin
    for (int i = 0; i < NumCtrs; i++) begin
      cntNext[i] = cnt[i];
      relNext[i] = strobe.direct[i];
      underV[i]  = 1'b0;
      overV[i]   = 1'b0;
      if (strobe.inc[i] && !strobe.dec[i]) begin
        if (cnt[i] == CntMax) overV[i] = 1'b1;
        else cntNext[i] = cnt[i] + CntOne;
      end else if (strobe.dec[i] && !strobe.inc[i]) begin
        if (cnt[i] == '0) underV[i] = 1'b1;
        else begin
          cntNext[i] = cnt[i] - CntOne;
          if (cnt[i] == CntOne) relNext[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumCtrs; i++) cnt[i] <= '0;
      relVec       <= '0;
      instComplete <= 1'b0;
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      for (int i = 0; i < NumCtrs; i++) cnt[i] <= cntNext[i];
      relVec       <= relNext;
      instComplete <= |relNext;
      underflowErr <= |underV;
      overflowErr  <= |overV;
    end
  end

  // R7
  complete_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    instComplete |-> $past(|(strobe.dec | strobe.direct)))
    else $error("completion without a writeback");
  // R8
  underflow_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> $past(|strobe.dec))
    else $error("underflow without a decrement");
  // R9
  overflow_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> $past(|strobe.inc))
    else $error("overflow without an increment");

  for (genvar g = 0; g < NumCtrs; g++) begin : gCtrChk
    // R5
    rel_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (relVec[g] && !$past(strobe.direct[g])) |-> cnt[g] == '0)
      else $error("release with a nonzero counter");
    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (int'(cnt[g]) - int'($past(cnt[g])) <= 1) &&
      (int'(cnt[g]) - int'($past(cnt[g])) >= -1))
      else $error("counter moved by more than one");
  end
endmodule

// File: rtl/ptrk_top.sv
`timescale 1ns/1ps
module ptrk_top import ptrk_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic                issueShared,
  input  src_list_t           issueSrcs,
  input  src_entry_t          issueStamp,
  input  logic [WarpBits-1:0] issuePrimWarp,
  input  logic                wbValid,
  input  logic                wbShared,
  input  src_list_t           wbSrcs,
  input  src_entry_t          wbStamp,
  input  logic [WarpBits-1:0] wbPrimWarp,
  output logic [PrimCtrs-1:0] relPrimary,
  output logic [SecCtrs-1:0]  relSecondary,
  output logic                instComplete,
  output logic                underflowErr,
  output logic                overflowErr
);
  strobe_t            strobe;
  logic [NumCtrs-1:0] relVec;

  ptrk_ctrl uCtrl (
    .issueValid(issueValid), .issueShared(issueShared), .issueSrcs(issueSrcs),
    .issueStamp(issueStamp), .issuePrimWarp(issuePrimWarp),
    .wbValid(wbValid), .wbShared(wbShared), .wbSrcs(wbSrcs),
    .wbStamp(wbStamp), .wbPrimWarp(wbPrimWarp), .strobe(strobe)
  );

  ptrk_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .relVec(relVec),
    .instComplete(instComplete), .underflowErr(underflowErr),
    .overflowErr(overflowErr)
  );

  assign relPrimary   = relVec[PrimCtrs-1:0];
  assign relSecondary = relVec[NumCtrs-1:PrimCtrs];
endmodule

// File: tb/sim_ptrk_top.sv
`timescale 1ns/1ps
module sim_ptrk_top;
  import ptrk_pkg::*;

  typedef struct packed {
    src_list_t           srcs;
    src_entry_t          stamp;
    logic [WarpBits-1:0] primWarp;
    logic                shared;
  } acc_t;

  typedef struct {
    logic [NumCtrs-1:0] rel;
    logic               comp;
    logic               und;
    logic               ovf;
    string              tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic                issueValid = 1'b0, issueShared = 1'b0;
  src_list_t           issueSrcs = '0;
  src_entry_t          issueStamp = '0;
  logic [WarpBits-1:0] issuePrimWarp = '0;
  logic                wbValid = 1'b0, wbShared = 1'b0;
  src_list_t           wbSrcs = '0;
  src_entry_t          wbStamp = '0;
  logic [WarpBits-1:0] wbPrimWarp = '0;
  logic [PrimCtrs-1:0] relPrimary;
  logic [SecCtrs-1:0]  relSecondary;
  logic                instComplete, underflowErr, overflowErr;

  int   checks = 0;
  int   errors = 0;
  exp_t expQ[$];
  int   model[NumCtrs];
  acc_t idle = '0;

  ptrk_top u0 (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueShared(issueShared), .issueSrcs(issueSrcs),
    .issueStamp(issueStamp), .issuePrimWarp(issuePrimWarp),
    .wbValid(wbValid), .wbShared(wbShared), .wbSrcs(wbSrcs),
    .wbStamp(wbStamp), .wbPrimWarp(wbPrimWarp),
    .relPrimary(relPrimary), .relSecondary(relSecondary),
    .instComplete(instComplete), .underflowErr(underflowErr),
    .overflowErr(overflowErr)
  );

  // Source with up to two destination registers; a negative register is unused.
  function automatic src_entry_t mkSrc(int w, int s, int r0, int r1);
    src_entry_t e;
    e = '0;
    e.valid = 1'b1;
    e.warp  = WarpBits'(w);
    e.split = SplitBits'(s);
    if (r0 >= 0) begin e.dst[0].used = 1'b1; e.dst[0].regIdx = RegBits'(r0); end
    if (r1 >= 0) begin e.dst[1].used = 1'b1; e.dst[1].regIdx = RegBits'(r1); end
    return e;
  endfunction

  function automatic acc_t mkAcc(src_entry_t a, src_entry_t b, src_entry_t c, logic sh);
    acc_t x;
    x = '0;
    x.srcs[0] = a;
    x.srcs[1] = b;
    x.srcs[2] = c;
    x.shared  = sh;
    return x;
  endfunction

  // Bitmap positions from R3
  function automatic int keyOf(int w, int s, int r);
    if (s == 3) return w * 16 + r;
    if (s < 2) return PrimCtrs + (w * 2 + s) * 16 + r;
    return -1;
  endfunction

  function automatic logic [NumCtrs-1:0] touched(acc_t a);
    logic [NumCtrs-1:0] v;
    src_list_t l;
    logic any;
    int k;
    v = '0;
    l = a.srcs;
    any = 1'b0;
    for (int s = 0; s < MaxSrc; s++) any |= l[s].valid;
    if (!any) begin
      l = '0;
      l[0] = a.stamp;
      l[0].valid = 1'b1;
      if (!a.stamp.valid) begin l[0].warp = a.primWarp; l[0].split = '1; end
    end
    for (int s = 0; s < MaxSrc; s++)
      for (int d = 0; d < NumSlots; d++)
        if (l[s].valid && l[s].dst[d].used) begin
          k = keyOf(int'(l[s].warp), int'(l[s].split), int'(l[s].dst[d].regIdx));
          if (k >= 0) v[k] = 1'b1;
        end
    return v;
  endfunction

  task automatic check(string tag, string what, logic [NumCtrs-1:0] act, logic [NumCtrs-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Driver: drive one cycle, push the expected outputs of the following cycle.
  task automatic step(string tag, logic iv, acc_t ia, logic wv, acc_t wa);
    logic [NumCtrs-1:0] incF, decF, dirF, tw;
    exp_t e;
    @(negedge clk);
    issueValid = iv; issueShared = ia.shared; issueSrcs = ia.srcs;
    issueStamp = ia.stamp; issuePrimWarp = ia.primWarp;
    wbValid = wv; wbShared = wa.shared; wbSrcs = wa.srcs;
    wbStamp = wa.stamp; wbPrimWarp = wa.primWarp;
    incF = (iv && !ia.shared) ? touched(ia) : '0;
    tw   = wv ? touched(wa) : '0;
    decF = wa.shared ? '0 : tw;
    dirF = wa.shared ? tw : '0;
    e.rel = dirF; e.und = 1'b0; e.ovf = 1'b0; e.tag = tag;
    for (int k = 0; k < NumCtrs; k++) begin
      if (incF[k] && !decF[k]) begin
        if (model[k] == 15) e.ovf = 1'b1;
        else model[k]++;
      end else if (decF[k] && !incF[k]) begin
        if (model[k] == 0) e.und = 1'b1;
        else begin
          model[k]--;
          if (model[k] == 0) e.rel[k] = 1'b1;
        end
      end
    end
    e.comp = |e.rel;
    expQ.push_back(e);
  endtask

  // Monitor: compare one expected item per cycle, away from the edge.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check(e.tag, "relPrimary", NumCtrs'(relPrimary), NumCtrs'(e.rel[PrimCtrs-1:0]));
      check(e.tag, "relSecondary", NumCtrs'(relSecondary), NumCtrs'(e.rel[NumCtrs-1:PrimCtrs]));
      // R7
      check(e.tag, "instComplete R7", NumCtrs'(instComplete), NumCtrs'(e.comp));
      check(e.tag, "underflowErr", NumCtrs'(underflowErr), NumCtrs'(e.und));
      check(e.tag, "overflowErr", NumCtrs'(overflowErr), NumCtrs'(e.ovf));
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    acc_t a, b, pool[6];
    int ord[6];
    for (int k = 0; k < NumCtrs; k++) model[k] = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "relPrimary", NumCtrs'(relPrimary), '0);
    check("R1", "relSecondary", NumCtrs'(relSecondary), '0);
    check("R1", "pulses", NumCtrs'({instComplete, underflowErr, overflowErr}), '0);
    @(negedge clk);
    rstN = 1'b1;
    // R1 fresh counter is zero: first writeback underflows
    step("R1", 1'b0, idle, 1'b1, mkAcc(mkSrc(7, 3, 15, -1), '0, '0, 1'b0));

    // R2 R5 two accesses, release only after the second return
    a = mkAcc(mkSrc(1, 3, 2, 3), '0, '0, 1'b0);
    step("R2", 1'b1, a, 1'b0, idle);
    step("R2", 1'b1, a, 1'b0, idle);
    step("R5", 1'b0, idle, 1'b1, a);
    step("R5", 1'b0, idle, 1'b1, a);
    step("R5", 1'b0, idle, 1'b0, idle);

    // R3 secondary splits are separate counters; split code 2 ignored
    a = mkAcc(mkSrc(2, 1, 5, -1), '0, '0, 1'b0);
    b = mkAcc(mkSrc(2, 0, 5, -1), '0, '0, 1'b0);
    step("R3", 1'b1, a, 1'b0, idle);
    step("R3", 1'b1, b, 1'b0, idle);
    step("R3", 1'b0, idle, 1'b1, a);
    step("R3", 1'b0, idle, 1'b1, b);
    a = mkAcc(mkSrc(3, 2, 4, -1), '0, '0, 1'b0);
    step("R3", 1'b1, a, 1'b0, idle);
    step("R3", 1'b0, idle, 1'b1, a);
    step("R3", 1'b0, idle, 1'b1, mkAcc(mkSrc(3, 3, 4, -1), '0, '0, 1'b0));
    step("R3", 1'b0, idle, 1'b1, mkAcc(mkSrc(3, 0, 4, -1), '0, '0, 1'b0));

    // R4 empty list: unset stamp charges the primary warp
    a = idle;
    a.stamp = mkSrc(0, 0, 7, -1);
    a.stamp.valid = 1'b0;
    a.primWarp = 3'd4;
    step("R4", 1'b1, a, 1'b0, idle);
    step("R4", 1'b0, idle, 1'b1, mkAcc(mkSrc(4, 3, 7, -1), '0, '0, 1'b0));
    // R4 set stamp is used as given
    a = idle;
    a.stamp = mkSrc(6, 1, 9, 10);
    step("R4", 1'b1, a, 1'b0, idle);
    step("R4", 1'b0, idle, 1'b1, a);

    // R6 merged access retires three sources at once
    a = mkAcc(mkSrc(0, 3, 1, -1), mkSrc(0, 0, 1, -1), mkSrc(5, 1, 9, 12), 1'b0);
    step("R6", 1'b1, a, 1'b0, idle);
    step("R6", 1'b0, idle, 1'b1, a);

    // R8 underflow on an idle register
    step("R8", 1'b0, idle, 1'b1, mkAcc(mkSrc(2, 3, 11, -1), '0, '0, 1'b0));
    step("R8", 1'b0, idle, 1'b0, idle);

    // R9 saturation, then drain
    a = mkAcc(mkSrc(7, 0, 6, -1), '0, '0, 1'b0);
    for (int i = 0; i < 16; i++) step("R9", 1'b1, a, 1'b0, idle);
    for (int i = 0; i < 16; i++) step("R9", 1'b0, idle, 1'b1, a);

    // R10 shared: no count at issue, direct release at writeback
    a = mkAcc(mkSrc(1, 3, 8, 9), '0, '0, 1'b1);
    step("R10", 1'b1, a, 1'b0, idle);
    step("R10", 1'b0, idle, 1'b1, a);
    a.shared = 1'b0;
    step("R10", 1'b0, idle, 1'b1, a);

    // R11 coincident issue and writeback on one counter
    a = mkAcc(mkSrc(6, 3, 0, -1), '0, '0, 1'b0);
    step("R11", 1'b1, a, 1'b0, idle);
    step("R11", 1'b1, a, 1'b1, a);
    step("R11", 1'b0, idle, 1'b1, a);

    // R5 R6 random merged accesses returned out of order
    for (int i = 0; i < 6; i++) begin
      int ns, r0;
      pool[i] = idle;
      ns = 1 + int'($urandom % 3);
      for (int s = 0; s < ns; s++) begin
        int sp;
        sp = int'($urandom % 3);
        if (sp == 2) sp = 3;
        r0 = int'($urandom % 16);
        pool[i].srcs[s] = mkSrc((i + 3 * s) % 8, sp, r0, (r0 + 1 + int'($urandom % 14)) % 16);
      end
      ord[i] = i;
    end
    for (int i = 0; i < 6; i++) step("R6", 1'b1, pool[i], 1'b0, idle);
    for (int i = 5; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = ord[i]; ord[i] = ord[j]; ord[j] = t;
    end
    for (int i = 0; i < 6; i++) begin
      step("R5", 1'b0, idle, 1'b1, pool[ord[i]]);
      step("R5", 1'b0, idle, 1'b0, idle);
    end

    step("R1", 1'b0, idle, 1'b0, idle);
    while (expQ.size() > 0) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule